// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

One down-counter channel with six output behaviours. A control block selects the behaviour and the number format with a one-cycle mode write. A one-cycle count strobe then supplies the start value. The channel counts on every rising edge of `clk` and drives `out_o`. Its count element is visible on `count_o`. The flag `null_cnt_o` shows that a written count has not yet reached the count element. `gate` either enables counting or starts a countdown on its rising edge, depending on the behaviour.

The count value and the mode travel on plain strobes with no handshake. A strobe is taken on the edge where it is high, and the channel is ready every cycle. A mode write in the same cycle as a count strobe takes precedence, and the count strobe is dropped. Counts are binary over `WIDTH` bits or BCD over `WIDTH/4` digits. `WIDTH` must be a multiple of 4. Modes 2 and 3 need a count of at least 2.

Top module: `interval_counter`

## Requirements
- R1: After reset, `count_o` is 0, `out_o` is low and `null_cnt_o` is high.
- R2: A mode write (`mode_sel` 0..5; 6 and 7 act as 2 and 3) stops counting and sets `null_cnt_o`. It drives `out_o` low for mode 0 and high for every other mode.
- R3: A count strobe sets `null_cnt_o` on the next edge. The flag clears on the edge that copies the count into `count_o`.
- R4: Mode 0: `out_o` goes low on the strobe edge. The count is copied on the following edge, and `out_o` rises on the edge where `count_o` reaches 0. A strobe during a countdown halts it, and the countdown restarts from the new value one edge later.
- R5: In modes 0, 2, 3 and 4, a low `gate` freezes `count_o`.
- R6: Mode 1: a rising `gate` loads the count and drives `out_o` low. `out_o` returns high on the edge where the count reaches 0. A count strobe during the pulse changes nothing until the next rising `gate`.
- R7: Mode 2: `out_o` is low for one clock in each period of N clocks, while the count is 1. A new count takes effect only at the reload that ends the current period.
- R8: Mode 3: the count drops by 2 per clock. `out_o` is high for ceil(N/2) clocks and low for floor(N/2) clocks. A new count takes effect at the next half-period boundary.
- R9: Mode 4: the count is copied one edge after the strobe. `out_o` goes low for exactly one clock on the edge where the count reaches 0.
- R10: Mode 5: a rising `gate` loads the count. `out_o` goes low for exactly one clock on the edge where the count reaches 0.
- R11: With BCD set, the counter borrows across decimal digits, so 0x0100 steps to 0x0099 and 0x0000 steps to 0x9999.
- R12: A count of 0 means the full range. In mode 0, `out_o` rises 65536 clocks after the copy in binary and 10000 clocks after the copy in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Operating mode |
| bcd_sel | input | 1 | 1 selects BCD counting |
| load_stb | input | 1 | Count write strobe |
| load_val | input | WIDTH | Count value |
| gate | input | 1 | Count enable or trigger |
| count_o | output | WIDTH | Count element |
| out_o | output | 1 | Timer output |
| null_cnt_o | output | 1 | Written count not yet in use |

## Verification
The bench measures the high and low lengths of the periodic modes over even, odd and BCD counts. An odd square-wave count that used N/2 for both halves would show up as a long or short period, and a rate generator whose low slot was misplaced would too. The tests write new counts mid-period, mid-pulse and mid-countdown. A design that reloads early would show the new value too soon in modes 1, 2 and 3, and one that fails to halt would reach 0 on the old count in mode 0. A count of zero is run to completion in both number formats, which exposes a counter that stops at zero or one that wraps to the binary maximum while in BCD.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ivc_mode_e;
endpackage

// File: rtl/ivc_gate_edge.sv
module ivc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;
  // Reset high so a gate already high at reset is not a trigger.
  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate;
  end
  assign rise = gate & ~gate_q;
endmodule

// File: rtl/ivc_step.sv
module ivc_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  input  logic [1:0]   amt,
  output logic [W-1:0] res
);
  localparam int ND = W / 4;
  logic [ND:0]  brw;
  logic [W-1:0] bcd_res;

  assign brw[0] = 1'b0;
  generate
    for (genvar d = 0; d < ND; d++) begin : g_dig
      logic [4:0] lhs, rhs;
      assign lhs = {1'b0, val[4*d +: 4]};
      assign rhs = {3'b000, (d == 0) ? amt : 2'b00} + {4'b0000, brw[d]};
      assign brw[d+1] = lhs < rhs;
      assign bcd_res[4*d +: 4] = brw[d+1] ? 4'(lhs + 5'd10 - rhs) : 4'(lhs - rhs);
    end
  endgenerate

  assign res = bcd ? bcd_res : val - W'(amt);
endmodule

// File: rtl/ivc_phase.sv
module ivc_phase #(
  parameter int W = 16
) (
  input  logic [W-1:0] cr,
  input  logic         bcd,
  output logic [W-1:0] hi_ld,
  output logic [W-1:0] lo_ld
);
  localparam int ND = W / 4;
  logic [ND:0]  cy;
  logic [W-1:0] inc_bcd, inc_val;

  assign cy[0] = 1'b1;
  generate
    for (genvar d = 0; d < ND; d++) begin : g_dig
      logic [4:0] s;
      assign s = {1'b0, cr[4*d +: 4]} + {4'b0000, cy[d]};
      assign cy[d+1] = s >= 5'd10;
      assign inc_bcd[4*d +: 4] = cy[d+1] ? 4'(s - 5'd10) : s[3:0];
    end
  endgenerate

  assign inc_val = bcd ? inc_bcd : cr + W'(1);
  // Odd counts: high half counts from N+1, low half from N-1.
  assign hi_ld = cr[0] ? inc_val : cr;
  assign lo_ld = {cr[W-1:1], 1'b0};
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ivc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_sel,
  input  logic             bcd_sel,
  input  logic             load_stb,
  input  logic [WIDTH-1:0] load_val,
  input  logic             gate,
  output logic [WIDTH-1:0] count_o,
  output logic             out_o,
  output logic             null_cnt_o
);
  ivc_mode_e        mode_q, mode_in;
  logic             bcd_q;
  logic [WIDTH-1:0] cr_q, cnt_q;
  logic             out_q, null_q, have_q, pend_q, run_q, armed_q;
  logic             rise, is_cnt1, is_cnt2, trig_mode;
  logic [WIDTH-1:0] dec1, dec2, hi_ld, lo_ld;

  ivc_gate_edge u_edge (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(rise));
  ivc_step #(.W(WIDTH)) u_dec1 (.val(cnt_q), .bcd(bcd_q), .amt(2'd1), .res(dec1));
  ivc_step #(.W(WIDTH)) u_dec2 (.val(cnt_q), .bcd(bcd_q), .amt(2'd2), .res(dec2));
  ivc_phase #(.W(WIDTH)) u_phase (.cr(cr_q), .bcd(bcd_q), .hi_ld(hi_ld), .lo_ld(lo_ld));

  always_comb mode_in = ivc_mode_e'((mode_sel[2:1] == 2'b11) ? {1'b0, mode_sel[1:0]} : mode_sel);
  assign is_cnt1   = cnt_q == WIDTH'(1);
  assign is_cnt2   = cnt_q == WIDTH'(2);
  assign trig_mode = (mode_q == MD_ONESHOT) || (mode_q == MD_HWSTROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_TERM; bcd_q <= 1'b0; cr_q <= '0; cnt_q <= '0;
      out_q <= 1'b0; null_q <= 1'b1; have_q <= 1'b0; pend_q <= 1'b0;
      run_q <= 1'b0; armed_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q  <= mode_in;
      bcd_q   <= bcd_sel;
      out_q   <= (mode_in != MD_TERM);
      null_q  <= 1'b1;
      have_q  <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (pend_q) begin
        cnt_q   <= (mode_q == MD_SQUARE) ? hi_ld : cr_q;
        null_q  <= 1'b0;
        pend_q  <= 1'b0;
        run_q   <= 1'b1;
        armed_q <= 1'b1;
        out_q   <= (mode_q != MD_TERM);
      end else if (trig_mode && rise && have_q) begin
        cnt_q   <= cr_q;
        null_q  <= 1'b0;
        run_q   <= 1'b1;
        armed_q <= 1'b1;
        out_q   <= (mode_q != MD_ONESHOT);
      end else if (run_q) begin
        unique case (mode_q)
          MD_TERM, MD_SWSTROBE: begin
            if (mode_q == MD_SWSTROBE) out_q <= 1'b1;
            if (gate) begin
              cnt_q <= dec1;
              if (armed_q && is_cnt1) begin
                armed_q <= 1'b0;
                out_q   <= (mode_q == MD_TERM);
              end
            end
          end
          MD_ONESHOT, MD_HWSTROBE: begin
            if (mode_q == MD_HWSTROBE) out_q <= 1'b1;
            cnt_q <= dec1;
            if (armed_q && is_cnt1) begin
              armed_q <= 1'b0;
              out_q   <= (mode_q == MD_ONESHOT);
            end
          end
          MD_RATE: begin
            if (gate) begin
              if (is_cnt1) begin
                cnt_q  <= cr_q;
                out_q  <= 1'b1;
                null_q <= 1'b0;
              end else begin
                cnt_q <= dec1;
                out_q <= !is_cnt2;
              end
            end
          end
          MD_SQUARE: begin
            if (gate) begin
              if (is_cnt2) begin
                out_q  <= !out_q;
                cnt_q  <= out_q ? lo_ld : hi_ld;
                null_q <= 1'b0;
              end else begin
                cnt_q <= dec2;
              end
            end
          end
          default: ;
        endcase
      end
      // Count strobe handled last so its effects win over the count path.
      if (load_stb) begin
        cr_q   <= load_val;
        null_q <= 1'b1;
        have_q <= 1'b1;
        if (mode_q == MD_TERM || mode_q == MD_SWSTROBE) begin
          pend_q <= 1'b1;
          run_q  <= 1'b0;
          out_q  <= (mode_q != MD_TERM);
        end else if ((mode_q == MD_RATE || mode_q == MD_SQUARE) && !run_q) begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign count_o    = cnt_q;
  assign out_o      = out_q;
  assign null_cnt_o = null_q;
endmodule

// File: rtl/interval_counter_chk.sv
module interval_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic             load_stb,
  input logic             gate,
  input logic [WIDTH-1:0] count_o,
  input logic             out_o,
  input logic             null_cnt_o,
  input logic [2:0]       mode_q,
  input logic             bcd_q,
  input logic             run_q,
  input logic             pend_q
);
  p_mode_wr_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (null_cnt_o && !run_q));

  p_null_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !mode_wr) |=> null_cnt_o);

  p_term_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && run_q && !out_o && gate && count_o == WIDTH'(1)
     && !load_stb && !mode_wr && !pend_q) |=> out_o);

  p_gate_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd0 || mode_q == 3'd2 || mode_q == 3'd3 || mode_q == 3'd4)
     && !gate && !load_stb && !mode_wr && !pend_q) |=> $stable(count_o));

  p_square_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3 && !bcd_q && run_q && gate && count_o != WIDTH'(2)
     && !load_stb && !mode_wr && !pend_q) |=> (count_o == $past(count_o) - WIDTH'(2)));

  // Also covers R10 (mode 5 strobe width).
  p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !out_o && !mode_wr) |=> out_o);
endmodule

bind interval_counter interval_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .load_stb(load_stb), .gate(gate),
  .count_o(count_o), .out_o(out_o), .null_cnt_o(null_cnt_o),
  .mode_q(mode_q), .bcd_q(bcd_q), .run_q(run_q), .pend_q(pend_q)
);

// File: tb/interval_counter_test.sv
`timescale 1ns/1ps
module interval_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        bcd_sel = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic        gate = 1'b0;
  logic [15:0] count_o;
  logic        out_o, null_cnt_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_counter #(.WIDTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .bcd_sel(bcd_sel), .load_stb(load_stb), .load_val(load_val), .gate(gate),
    .count_o(count_o), .out_o(out_o), .null_cnt_o(null_cnt_o)
  );

  // {mode, bcd, count, expected high clocks, expected low clocks}
  localparam logic [39:0] VEC [8] = '{
    {4'd3, 4'd0, 16'd6,     8'd3,  8'd3},
    {4'd3, 4'd0, 16'd5,     8'd3,  8'd2},
    {4'd3, 4'd0, 16'd2,     8'd1,  8'd1},
    {4'd3, 4'd1, 16'h0011,  8'd6,  8'd5},
    {4'd3, 4'd1, 16'h0099,  8'd50, 8'd49},
    {4'd2, 4'd0, 16'd4,     8'd3,  8'd1},
    {4'd2, 4'd1, 16'h0010,  8'd9,  8'd1},
    {4'd2, 4'd0, 16'd7,     8'd6,  8'd1}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr_mode(input logic [2:0] m, input logic b);
    mode_sel = m; bcd_sel = b; mode_wr = 1'b1;
    step();
    mode_wr = 1'b0;
  endtask

  task automatic ld(input logic [15:0] v);
    load_val = v; load_stb = 1'b1;
    step();
    load_stb = 1'b0;
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-R: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lo, hi, guard, n;
    steps(2);
    rst_n = 1'b1;
    chk("R1", "count", count_o, 0);
    chk("R1", "out", out_o, 0);
    chk("R1", "null", null_cnt_o, 1);

    // Table: periodic output shapes for modes 2 and 3.
    gate = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wr_mode(VEC[i][38:36], VEC[i][32]);
      ld(VEC[i][31:16]);
      guard = 0;
      while (!out_o && guard < 400) begin step(); guard++; end
      while (out_o && guard < 400) begin step(); guard++; end
      lo = 0;
      while (!out_o && lo < 400) begin lo++; step(); end
      hi = 0;
      while (out_o && hi < 400) begin hi++; step(); end
      chk(VEC[i][38:36] == 3 ? "R8" : "R7", "low clocks", lo, int'(VEC[i][7:0]));
      chk(VEC[i][38:36] == 3 ? "R8" : "R7", "high clocks", hi, int'(VEC[i][15:8]));
    end

    // R2: mode write sets the output level
    wr_mode(3'd2, 1'b0);
    chk("R2", "out after mode 2", out_o, 1);
    chk("R2", "null after mode write", null_cnt_o, 1);
    wr_mode(3'd0, 1'b0);
    chk("R2", "out after mode 0", out_o, 0);
    wr_mode(3'd6, 1'b0);
    chk("R2", "out after mode 6", out_o, 1);

    // R4 / R3: mode 0 terminal count
    wr_mode(3'd0, 1'b0);
    ld(16'd5);
    chk("R3", "null after load", null_cnt_o, 1);
    chk("R4", "out after load", out_o, 0);
    step();
    chk("R4", "count copied", count_o, 5);
    chk("R3", "null cleared on copy", null_cnt_o, 0);
    steps(4);
    chk("R4", "count before zero", count_o, 1);
    chk("R4", "out before zero", out_o, 0);
    step();
    chk("R4", "count at zero", count_o, 0);
    chk("R4", "out at zero", out_o, 1);
    steps(2);
    chk("R4", "out stays high", out_o, 1);

    // R4: reload halts and restarts
    wr_mode(3'd0, 1'b0);
    ld(16'd10);
    step();
    steps(3);
    chk("R4", "count mid-run", count_o, 7);
    ld(16'd4);
    chk("R4", "count on reload edge", count_o, 6);
    step();
    chk("R4", "count restarted", count_o, 4);
    steps(3);
    chk("R4", "old count ignored", out_o, 0);
    step();
    chk("R4", "out after new count", out_o, 1);

    // R5: gate low freezes
    wr_mode(3'd0, 1'b0);
    gate = 1'b0;
    ld(16'd3);
    step();
    steps(5);
    chk("R5", "count frozen", count_o, 3);
    gate = 1'b1;
    step();
    chk("R5", "count resumes", count_o, 2);

    // R6: one-shot
    gate = 1'b0;
    wr_mode(3'd1, 1'b0);
    chk("R6", "out idle", out_o, 1);
    ld(16'd3);
    steps(3);
    chk("R6", "no trigger no pulse", out_o, 1);
    chk("R3", "null before trigger", null_cnt_o, 1);
    gate = 1'b1;
    step();
    chk("R6", "count on trigger", count_o, 3);
    chk("R6", "out low on trigger", out_o, 0);
    ld(16'd6);
    chk("R6", "reload ignored", count_o, 2);
    step();
    chk("R6", "count continues", count_o, 1);
    step();
    chk("R6", "out high at zero", out_o, 1);
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    chk("R6", "new count on retrigger", count_o, 6);
    chk("R6", "out low on retrigger", out_o, 0);

    // R7: rate generator reload at period end
    wr_mode(3'd2, 1'b0);
    ld(16'd4);
    step();
    steps(3);
    chk("R7", "low slot at one", out_o, 0);
    ld(16'd6);
    chk("R7", "old count reloaded", count_o, 4);
    chk("R3", "null pending", null_cnt_o, 1);
    steps(3);
    chk("R7", "low slot again", out_o, 0);
    step();
    chk("R7", "new count at period end", count_o, 6);
    chk("R3", "null cleared on reload", null_cnt_o, 0);

    // R8: square wave reload at half boundary
    wr_mode(3'd3, 1'b0);
    ld(16'd6);
    step();
    chk("R8", "high phase start", count_o, 6);
    step();
    chk("R8", "step by two", count_o, 4);
    ld(16'd10);
    chk("R8", "count on reload edge", count_o, 2);
    step();
    chk("R8", "new half count", count_o, 10);
    chk("R8", "out toggled low", out_o, 0);

    // R9: software strobe
    wr_mode(3'd4, 1'b0);
    ld(16'd3);
    chk("R9", "out high after load", out_o, 1);
    step();
    chk("R9", "count copied", count_o, 3);
    steps(2);
    chk("R9", "out high before zero", out_o, 1);
    step();
    chk("R9", "out low at zero", out_o, 0);
    step();
    chk("R9", "out back high", out_o, 1);
    chk("R9", "count wrapped", count_o, 16'hFFFF);

    // R10: hardware strobe
    gate = 1'b0;
    wr_mode(3'd5, 1'b0);
    ld(16'd2);
    steps(2);
    chk("R10", "idle without trigger", out_o, 1);
    gate = 1'b1;
    step();
    chk("R10", "count on trigger", count_o, 2);
    step();
    chk("R10", "out high", out_o, 1);
    step();
    chk("R10", "out low at zero", out_o, 0);
    step();
    chk("R10", "out back high", out_o, 1);

    // R11: BCD borrow
    wr_mode(3'd0, 1'b1);
    ld(16'h0100);
    step();
    step();
    chk("R11", "bcd borrow", count_o, 16'h0099);

    // R11 / R12: zero count in BCD
    wr_mode(3'd0, 1'b1);
    ld(16'h0000);
    step();
    step();
    chk("R11", "bcd wrap", count_o, 16'h9999);
    n = 1;
    while (!out_o && n < 20000) begin step(); n++; end
    chk("R12", "bcd full range clocks", n, 10000);

    // R12: zero count in binary
    wr_mode(3'd0, 1'b0);
    ld(16'h0000);
    step();
    n = 0;
    while (!out_o && n < 70000) begin step(); n++; end
    chk("R12", "binary full range clocks", n, 65536);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule